// File: doc/BRIEF.md
# Real-Time Interval Counter with Wake Request

This block keeps a running time of day and a separate programmable interval timer, both advanced by a slow 32.768 kHz tick delivered as a one-cycle enable pulse in the system clock domain. A prescaler divides the tick down to 1/128-second steps. Four cascaded fields (fractions, seconds, minutes, hours) count these steps and carry into one another. Software reads and writes every field and the control settings through a small synchronous register bus.

The interval timer counts units of a selectable size (1/128 s, second, minute or hour) against an 8-bit reload value. On expiry it sets a sticky flag. When the interrupt enable is set, the flag drives an interrupt request and a wake request toward a power controller. Either an interrupt acknowledge or a write of 1 to the flag bit clears the flag.

Register map (bus address): 0 control, 1 fraction, 2 seconds, 3 minutes, 4 hours, 5 interval reload, 6 interval count (read only), 7 reads zero. Control bits: bit0 run, bit1 interval enable, bit2 interrupt enable, bits[4:3] interval unit, bit5 expiry flag (read; write 1 to clear).

Top module: `rtc_interval_timer`

## Requirements
- R1: After reset, every register reads 0 (control included) and irq and wake_req are low.
- R2: While control bit0 (run) is set, the fraction field advances once per TICKS_PER_FRAC tick pulses. A bus write to the fraction register (address 1) also clears the prescaler.
- R3: With run clear, no tick pulse changes any time field or the interval count.
- R4: Fraction counts 0..127, seconds and minutes 0..59, hours 0..23. Each field wraps to 0 at its top count and carries one step into the next field, so 23:59:59.127 rolls to 00:00:00.000.
- R5: A value written to a time field that is above its top count is stored as 0.
- R6: The unit select in control bits[4:3] (00 fraction step, 01 second, 10 minute, 11 hour) picks what the interval count advances on. After the reload value (address 5) of units has passed, the flag (control bit5) is set and the count returns to 0. A reload of 0 means 256 units.
- R7: The flag stays set until a cycle with irq_ack high or a control write with bit5 = 1. A new expiry in the same cycle as a clear leaves the flag set.
- R8: irq and wake_req both equal the flag ANDed with control bit2 (interrupt enable), registered one clock later.
- R9: While control bit1 (interval enable) is clear, the interval count (address 6) holds 0. When the bit is set again, counting restarts from zero.
- R10: A write to a time field takes the written value even in a cycle where a carry reaches it. In that cycle any carry out of the written field is dropped.
- R11: bus_rdata presents the register selected by bus_addr one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interval interrupt request |
| wake_req | output | 1 | Wake request to the power controller |

## Verification
The bench builds the block with TICKS_PER_FRAC = 2, so two tick pulses make one fraction step. It preloads the fields through the bus to sit just before a carry. This puts the full 23:59:59.127 rollover, the minute and hour carries and an hour-unit interval expiry within a few ticks instead of a simulated day. With the other parameters at their defaults, the real field limits and the 8-bit reload are checked unchanged.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_FRAC   = 1;
  localparam int ADDR_SEC    = 2;
  localparam int ADDR_MIN    = 3;
  localparam int ADDR_HOUR   = 4;
  localparam int ADDR_RELOAD = 5;
  localparam int ADDR_COUNT  = 6;

  localparam int CB_RUN     = 0;
  localparam int CB_IVL     = 1;
  localparam int CB_IRQ     = 2;
  localparam int CB_UNIT_LO = 3;
  localparam int CB_FLAG    = 5;

  localparam int NUM_FIELDS = 4;

  typedef enum logic [1:0] {
    UNIT_FRAC = 2'd0,
    UNIT_SEC  = 2'd1,
    UNIT_MIN  = 2'd2,
    UNIT_HOUR = 2'd3
  } tic_unit_e;
endpackage

// File: rtl/tic_prescale.sv
module tic_prescale #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick_in,
  input  logic clr,
  output logic step
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run && tick_in) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign step = run && tick_in && !clr && (cnt_q == LAST);
endmodule

// File: rtl/tic_field.sv
module tic_field #(
  parameter int LAST = 59,
  parameter int W    = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         carry
);
  localparam logic [W-1:0] TOP = W'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (ld) begin
      val <= (ld_val > TOP) ? '0 : ld_val;
    end else if (step) begin
      val <= (val >= TOP) ? '0 : val + 1'b1;
    end
  end

  assign carry = step && !ld && (val >= TOP);
endmodule

// File: rtl/tic_interval.sv
module tic_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         pulse,
  input  logic [W-1:0] reload,
  output logic         expire,
  output logic [W-1:0] count
);
  logic at_end;

  assign at_end = (count == reload - W'(1));
  assign expire = en && pulse && at_end;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      count <= '0;
    end else if (pulse) begin
      count <= at_end ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer
  import tic_pkg::*;
#(
  parameter int TICKS_PER_FRAC = 256,
  parameter int FRAC_LAST      = 127,
  parameter int SEC_LAST       = 59,
  parameter int MIN_LAST       = 59,
  parameter int HOUR_LAST      = 23,
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              wake_req
);
  function automatic int field_last(input int idx);
    case (idx)
      0:       return FRAC_LAST;
      1:       return SEC_LAST;
      2:       return MIN_LAST;
      default: return HOUR_LAST;
    endcase
  endfunction

  logic            run_q, ivl_en_q, irq_en_q, flag_q;
  tic_unit_e       unit_q;
  logic [DATA_W-1:0] reload_q;

  logic              wr_ctrl, wr_reload, frac_step;
  logic [NUM_FIELDS-1:0] fstep, fcarry, fld;
  logic [DATA_W-1:0] fval [NUM_FIELDS];

  logic              unit_pulse, expire;
  logic [DATA_W-1:0] ivl_count;

  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_reload = bus_wr && (bus_addr == ADDR_W'(ADDR_RELOAD));

  tic_prescale #(.DIV(TICKS_PER_FRAC)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .tick_in (tick_in),
    .clr     (fld[0]),
    .step    (frac_step)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign fld[i] = bus_wr && (bus_addr == ADDR_W'(ADDR_FRAC + i));
    if (i == 0) begin : g_first
      assign fstep[i] = frac_step;
    end else begin : g_next
      assign fstep[i] = fcarry[i-1];
    end
    tic_field #(.LAST(field_last(i)), .W(DATA_W)) u_fld (
      .clk    (clk),
      .rst    (rst),
      .step   (fstep[i]),
      .ld     (fld[i]),
      .ld_val (bus_wdata),
      .val    (fval[i]),
      .carry  (fcarry[i])
    );
  end

  always_comb begin
    case (unit_q)
      UNIT_FRAC: unit_pulse = frac_step;
      UNIT_SEC:  unit_pulse = fcarry[0];
      UNIT_MIN:  unit_pulse = fcarry[1];
      default:   unit_pulse = fcarry[2];
    endcase
  end

  tic_interval #(.W(DATA_W)) u_ivl (
    .clk    (clk),
    .rst    (rst),
    .en     (ivl_en_q),
    .pulse  (unit_pulse),
    .reload (reload_q),
    .expire (expire),
    .count  (ivl_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      ivl_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      unit_q   <= UNIT_FRAC;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q    <= bus_wdata[CB_RUN];
        ivl_en_q <= bus_wdata[CB_IVL];
        irq_en_q <= bus_wdata[CB_IRQ];
        unit_q   <= tic_unit_e'(bus_wdata[CB_UNIT_LO +: 2]);
      end
      if (wr_reload) begin
        reload_q <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (irq_ack || (wr_ctrl && bus_wdata[CB_FLAG])) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      irq      <= flag_q && irq_en_q;
      wake_req <= flag_q && irq_en_q;
    end
  end

  logic [DATA_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view                    = '0;
    ctrl_view[CB_RUN]            = run_q;
    ctrl_view[CB_IVL]            = ivl_en_q;
    ctrl_view[CB_IRQ]            = irq_en_q;
    ctrl_view[CB_UNIT_LO +: 2]   = unit_q;
    ctrl_view[CB_FLAG]           = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(ADDR_CTRL):   bus_rdata <= ctrl_view;
        ADDR_W'(ADDR_FRAC):   bus_rdata <= fval[0];
        ADDR_W'(ADDR_SEC):    bus_rdata <= fval[1];
        ADDR_W'(ADDR_MIN):    bus_rdata <= fval[2];
        ADDR_W'(ADDR_HOUR):   bus_rdata <= fval[3];
        ADDR_W'(ADDR_RELOAD): bus_rdata <= reload_q;
        ADDR_W'(ADDR_COUNT):  bus_rdata <= ivl_count;
        default:              bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
  parameter int HOUR_LAST = 23,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_ack,
  input logic [DATA_W-1:0] frac,
  input logic [DATA_W-1:0] hour,
  input logic              min_carry,
  input logic              flag,
  input logic              irq_en,
  input logic              ivl_en,
  input logic [DATA_W-1:0] ivl_cnt,
  input logic              irq,
  input logic              wake_req
);
  logic frac_wr, hour_wr, flag_clr;
  assign frac_wr  = bus_wr && (bus_addr == ADDR_W'(1));
  assign hour_wr  = bus_wr && (bus_addr == ADDR_W'(4));
  assign flag_clr = irq_ack || (bus_wr && (bus_addr == ADDR_W'(0)) && bus_wdata[5]);

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst)
    hour <= DATA_W'(HOUR_LAST)); // R4
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (min_carry && hour == DATA_W'(HOUR_LAST) && !hour_wr) |=> (hour == '0)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !frac_wr) |=> $stable(frac)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && irq_en)); // R8
  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(flag && irq_en)); // R8
  AST_IVL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ivl_en |=> (ivl_cnt == '0)); // R9
endmodule

bind rtc_interval_timer tic_checker #(
  .HOUR_LAST (HOUR_LAST),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run_q),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_ack   (irq_ack),
  .frac      (fval[0]),
  .hour      (fval[3]),
  .min_carry (fcarry[2]),
  .flag      (flag_q),
  .irq_en    (irq_en_q),
  .ivl_en    (ivl_en_q),
  .ivl_cnt   (ivl_count),
  .irq       (irq),
  .wake_req  (wake_req)
);

// File: tb/rtc_interval_timer_tb.sv
module rtc_interval_timer_tb;
  localparam int TPF    = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq_ack = 1'b0;
  logic irq, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_interval_timer #(.TICKS_PER_FRAC(TPF), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .irq(irq), .wake_req(wake_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    @(negedge clk);
    chk(req, int'(bus_rdata), exp);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 7; a++) rd_chk("R1 reset reg", a, 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 wake after reset", int'(wake_req), 0);
  endtask

  task automatic t_count();
    wr(1, 0); wr(0, 8'h01);
    tick(10); rd_chk("R2 frac after 10 ticks", 1, 5);
    tick(1);  rd_chk("R2 frac mid prescale", 1, 5);
    tick(1);  rd_chk("R11 frac after step", 1, 6);
  endtask

  task automatic t_freeze();
    wr(0, 8'h00);
    tick(8); rd_chk("R3 frac frozen", 1, 6);
  endtask

  task automatic t_clamp();
    wr(2, 70); rd_chk("R5 sec over top", 2, 0);
    wr(4, 24); rd_chk("R5 hour over top", 4, 0);
    wr(3, 59); rd_chk("R5 min at top kept", 3, 59);
  endtask

  task automatic t_rollover();
    wr(4, 23); wr(3, 59); wr(2, 59); wr(1, 127); wr(0, 8'h01);
    tick(1); rd_chk("R4 frac before wrap", 1, 127);
    tick(1);
    rd_chk("R4 frac wrap", 1, 0);
    rd_chk("R4 sec wrap", 2, 0);
    rd_chk("R4 min wrap", 3, 0);
    rd_chk("R4 hour wrap", 4, 0);
    wr(3, 5); wr(2, 59); wr(1, 127);
    tick(2);
    rd_chk("R4 min carry", 3, 6);
    rd_chk("R4 sec after carry", 2, 0);
  endtask

  task automatic t_carry_write();
    wr(3, 7); wr(2, 59); wr(1, 127);
    tick(1);
    @(negedge clk);
    tick_in = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(2); bus_wdata = 8'd10;
    @(negedge clk);
    tick_in = 1'b0; bus_wr = 1'b0;
    rd_chk("R10 frac stepped", 1, 0);
    rd_chk("R10 sec takes write", 2, 10);
    rd_chk("R10 min no carry", 3, 7);
  endtask

  task automatic t_interval();
    wr(5, 3); wr(1, 0); wr(0, 8'h07);
    tick(5);
    rd_chk("R6 no flag before reload", 0, 8'h07);
    chk("R8 irq low before expiry", int'(irq), 0);
    tick(1);
    rd_chk("R6 flag at reload", 0, 8'h27);
    chk("R8 irq on expiry", int'(irq), 1);
    chk("R8 wake on expiry", int'(wake_req), 1);
    rd_chk("R6 count back to zero", 6, 0);
  endtask

  task automatic t_sticky();
    tick(2);
    rd_chk("R7 flag stays", 0, 8'h27);
    wr(0, 8'h27);
    rd_chk("R7 write1 clears", 0, 8'h07);
    chk("R8 irq drops", int'(irq), 0);
    tick(4);
    rd_chk("R6 second expiry", 0, 8'h27);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd_chk("R7 ack clears", 0, 8'h07);
  endtask

  task automatic t_restart();
    wr(0, 8'h05);
    rd_chk("R9 count held zero", 6, 0);
    tick(4);
    rd_chk("R9 still zero while off", 6, 0);
    wr(1, 0); wr(0, 8'h03);
    tick(2);
    rd_chk("R9 restarts from zero", 6, 1);
    tick(4);
    rd_chk("R8 flag without irq enable", 0, 8'h23);
    chk("R8 irq masked", int'(irq), 0);
    chk("R8 wake masked", int'(wake_req), 0);
  endtask

  task automatic t_hour_unit();
    wr(5, 1); wr(0, 8'h3F);
    wr(4, 4); wr(3, 59); wr(2, 59); wr(1, 127);
    tick(1);
    rd_chk("R6 hour unit no flag yet", 0, 8'h1F);
    tick(1);
    rd_chk("R4 hour advanced", 4, 5);
    rd_chk("R6 hour unit expiry", 0, 8'h3F);
    chk("R8 wake on hour expiry", int'(wake_req), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_freeze();
    t_clamp();
    t_rollover();
    t_carry_write();
    t_interval();
    t_sticky();
    t_restart();
    t_hour_unit();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule